// File: doc/BRIEF.md
# Dual-Dictionary Instruction Decompressor

This block sits between a compressed program store and an instruction fetch port. The program is held as a packed stream of variable-length codewords, and the block turns that stream back into 32-bit instructions. Each codeword starts with a 2-bit type tag. The tag selects one of four sources for the instruction: a short index into a small table of the most frequent instructions, a longer index into a large table, a large-table index plus a 2-bit correction patch at an aligned bit pair, or the full 32 raw bits.

Compressed memory words arrive 32 bits at a time through a valid/ready port and are appended to a shift buffer. Each cycle the codeword at the head of the buffer is decoded, provided all of its bits are present and the 4-entry output queue has room. The buffer then shifts by exactly that codeword's length, so the next codeword starts at bit 0. Decoded instructions leave through a 32-bit valid/ready port. Both tables are flip-flop arrays that are loaded through their own write ports before the program runs. Reset does not clear their contents.

Top module: `dd_decomp`

## Requirements
- R1: After a synchronous active-low reset, `ins_valid` is 0 and `cw_ready` is 1. The shift buffer and the output queue are empty.
- R2: Tag 00 (bits [1:0] of a codeword) is followed by a small-table index of SM_AW bits at codeword bits [2 +: SM_AW]. The instruction produced is the small-table entry at that index.
- R3: Tag 01 is followed by a large-table index of LG_AW bits at codeword bits [2 +: LG_AW]. The instruction produced is the large-table entry at that index.
- R4: Tag 10 carries a 4-bit position p at bits [5:2], a 2-bit patch q at bits [7:6] and a large-table index at bits [8 +: LG_AW]. The instruction is the entry XOR (q << 2p), so at most two bits differ from the entry.
- R5: Tag 11 is followed by 32 raw bits at codeword bits [33:2]. These bits are passed through unchanged as the instruction.
- R6: The stream is consumed least-significant bit first. Bit 0 of each input word follows bit 31 of the previous word, and codewords may span word boundaries. Instructions come out in stream order, with no instruction lost or added.
- R7: `cw_ready` is high exactly while fewer than 48 bits are buffered. With the output blocked from reset, a stream of raw codewords is accepted for exactly 6 words before `cw_ready` stays low.
- R8: The output queue holds 4 instructions. While `ins_valid` is high and `ins_ready` is low, `ins_data` holds steady. Decoding stalls while the queue is full and resumes without loss or duplication.
- R9: A write on a table's write port is seen by every codeword decoded after it. A rewritten entry yields its new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cw_valid | input | 1 | Compressed word offered |
| cw_data | input | 32 | Compressed word, bit 0 consumed first |
| cw_ready | output | 1 | Buffer accepts a word this cycle |
| sm_we | input | 1 | Small-table write enable |
| sm_waddr | input | SM_AW | Small-table write index |
| sm_wdata | input | 32 | Small-table write value |
| lg_we | input | 1 | Large-table write enable |
| lg_waddr | input | LG_AW | Large-table write index |
| lg_wdata | input | 32 | Large-table write value |
| ins_valid | output | 1 | Decoded instruction available |
| ins_data | output | 32 | Decoded instruction |
| ins_ready | input | 1 | Consumer takes the instruction |

## Verification
The bench builds the block with SM_AW=3 and LG_AW=5, which makes the codewords 5, 7, 13 and 34 bits long. At that size every small-table and large-table entry can be swept, together with all 16 patch positions times all 4 patch values. The odd lengths make codewords straddle word boundaries in every alignment. A blocked-output run from reset exposes the refill threshold and the queue depth at the ports, and randomly throttled output checks order across stalls.

// File: rtl/dd_pkg.sv
// Shared constants and codeword tag type for the dual-dictionary decompressor.
// Assumes 32-bit instructions and a 2-bit tag at the head of each codeword.
package dd_pkg;
    localparam int INSTR_W = 32;
    localparam int TAG_W   = 2;
    localparam int POS_W   = 4;
    localparam int PAT_W   = 2;
    localparam int RAW_LEN = TAG_W + INSTR_W;
    localparam int LEN_W   = 6;

    typedef enum logic [1:0] {
        CW_SMALL = 2'b00,
        CW_LARGE = 2'b01,
        CW_PATCH = 2'b10,
        CW_RAW   = 2'b11
    } cw_tag_e;
endpackage

// File: rtl/dd_lut.sv
// Flip-flop dictionary: one synchronous write port, one combinational read.
// Assumes contents are preloaded before use; reset leaves the storage alone.
module dd_lut #(
    parameter int AW = 4,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int ENTRIES = 1 << AW;

    logic [DW-1:0] mem [ENTRIES];

    // Store a preload word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the addressed entry.
    assign rdata = mem[raddr];
endmodule

// File: rtl/dd_shift_buf.sv
// Input realignment buffer. Words are appended above the valid bits and the
// head is shifted out by the consumed codeword length. Bits above the fill
// level are kept at zero, and the caller never takes more than is buffered.
module dd_shift_buf #(
    parameter int BUF_W  = 80,
    parameter int WORD_W = 32,
    parameter int REFILL = 48,
    parameter int WIN_W  = 34,
    parameter int LEN_W  = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [WORD_W-1:0]           in_data,
    output logic                        in_ready,
    output logic [WIN_W-1:0]            window,
    output logic [$clog2(BUF_W+1)-1:0]  level,
    input  logic                        take,
    input  logic [LEN_W-1:0]            take_len
);
    localparam int CNT_W = $clog2(BUF_W + 1);

    logic [BUF_W-1:0] buf_q, buf_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] used, rem;
    logic             accept;

    assign in_ready = (cnt_q < CNT_W'(REFILL));
    assign accept   = in_valid && in_ready;
    assign window   = buf_q[WIN_W-1:0];
    assign level    = cnt_q;

    // Drop the consumed head and append an accepted word above what remains.
    always_comb begin
        used  = take ? CNT_W'(take_len) : '0;
        rem   = cnt_q - used;
        buf_d = buf_q >> used;
        cnt_d = rem;
        if (accept) begin
            buf_d = buf_d | (BUF_W'(in_data) << rem);
            cnt_d = rem + CNT_W'(WORD_W);
        end
    end

    // Hold buffer contents and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            cnt_q <= '0;
        end else begin
            buf_q <= buf_d;
            cnt_q <= cnt_d;
        end
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(BUF_W)); // R7
    AST_TAKE_WITHIN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> CNT_W'(take_len) <= cnt_q); // R6
    AST_REFILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !take) |=> cnt_q == $past(cnt_q) + CNT_W'(WORD_W)); // R7
endmodule

// File: rtl/dd_decoder.sv
// Combinational codeword decoder. From the buffer head it forms the table
// read indices, the rebuilt instruction and the codeword length. It also
// reports whether the whole codeword is already buffered.
module dd_decoder
    import dd_pkg::*;
#(
    parameter int SM_AW = 4,
    parameter int LG_AW = 10,
    parameter int CNT_W = 7
) (
    input  logic [RAW_LEN-1:0] win,
    input  logic [CNT_W-1:0]   level,
    input  logic [INSTR_W-1:0] sm_rdata,
    input  logic [INSTR_W-1:0] lg_rdata,
    output logic [SM_AW-1:0]   sm_raddr,
    output logic [LG_AW-1:0]   lg_raddr,
    output cw_tag_e            tag,
    output logic [INSTR_W-1:0] instr,
    output logic [LEN_W-1:0]   cw_len,
    output logic               complete
);
    localparam int LEN_SM  = TAG_W + SM_AW;
    localparam int LEN_LG  = TAG_W + LG_AW;
    localparam int PAT_LSB = TAG_W + POS_W;
    localparam int IDX_LSB = PAT_LSB + PAT_W;
    localparam int LEN_PT  = IDX_LSB + LG_AW;

    logic [POS_W-1:0]   pos;
    logic [PAT_W-1:0]   pat;
    logic [INSTR_W-1:0] patch;

    assign tag      = cw_tag_e'(win[TAG_W-1:0]);
    assign pos      = win[TAG_W +: POS_W];
    assign pat      = win[PAT_LSB +: PAT_W];
    assign sm_raddr = win[TAG_W +: SM_AW];
    assign lg_raddr = (tag == CW_PATCH) ? win[IDX_LSB +: LG_AW] : win[TAG_W +: LG_AW];
    assign patch    = INSTR_W'(pat) << {pos, 1'b0};

    // Select the instruction source and codeword length by tag.
    always_comb begin
        unique case (tag)
            CW_SMALL: begin instr = sm_rdata;         cw_len = LEN_W'(LEN_SM);  end
            CW_LARGE: begin instr = lg_rdata;         cw_len = LEN_W'(LEN_LG);  end
            CW_PATCH: begin instr = lg_rdata ^ patch; cw_len = LEN_W'(LEN_PT);  end
            default:  begin instr = win[TAG_W +: INSTR_W]; cw_len = LEN_W'(RAW_LEN); end
        endcase
    end

    assign complete = (level >= CNT_W'(cw_len));
endmodule

// File: rtl/dd_out_fifo.sv
// Output instruction queue with an occupancy counter. It assumes the writer
// never pushes while full; the reader pops on a valid/ready handshake.
module dd_out_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         full,
    output logic         rd_valid,
    output logic [W-1:0] rd_data,
    input  logic         rd_ready
);
    localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCW = $clog2(DEPTH + 1);

    logic [W-1:0]   slots [DEPTH];
    logic [PW-1:0]  wp, rp;
    logic [OCW-1:0] occ;
    logic           pop;

    assign full     = (occ == OCW'(DEPTH));
    assign rd_valid = (occ != '0);
    assign rd_data  = slots[rp];
    assign pop      = rd_valid && rd_ready;

    // Write an entry into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push) slots[wp] <= push_data;
    end

    // Advance the pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            occ <= '0;
        end else begin
            if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            occ <= occ + OCW'(push) - OCW'(pop);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R8
    AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> rd_valid && $stable(rd_data)); // R8
endmodule

// File: rtl/dd_decomp.sv
// Top of the dual-dictionary instruction decompressor. It assumes the tables
// are loaded before any codeword that references them is streamed in, and that
// the stream is packed least-significant bit first.
module dd_decomp
    import dd_pkg::*;
#(
    parameter int SM_AW   = 4,
    parameter int LG_AW   = 10,
    parameter int Q_DEPTH = 4,
    parameter int BUF_W   = 80,
    parameter int REFILL  = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cw_valid,
    input  logic [31:0]        cw_data,
    output logic               cw_ready,
    input  logic               sm_we,
    input  logic [SM_AW-1:0]   sm_waddr,
    input  logic [31:0]        sm_wdata,
    input  logic               lg_we,
    input  logic [LG_AW-1:0]   lg_waddr,
    input  logic [31:0]        lg_wdata,
    output logic               ins_valid,
    output logic [31:0]        ins_data,
    input  logic               ins_ready
);
    localparam int CNT_W = $clog2(BUF_W + 1);

    logic [RAW_LEN-1:0] win;
    logic [CNT_W-1:0]   level;
    logic [SM_AW-1:0]   sm_raddr;
    logic [LG_AW-1:0]   lg_raddr;
    logic [INSTR_W-1:0] sm_rdata, lg_rdata, instr;
    logic [LEN_W-1:0]   cw_len;
    cw_tag_e            tag;
    logic               complete, q_full, fire;

    // Decode one codeword when it is fully buffered and the queue has room.
    assign fire = complete && !q_full;

    dd_shift_buf #(
        .BUF_W(BUF_W), .WORD_W(INSTR_W), .REFILL(REFILL),
        .WIN_W(RAW_LEN), .LEN_W(LEN_W)
    ) u_buf (
        .clk(clk), .rst_n(rst_n),
        .in_valid(cw_valid), .in_data(cw_data), .in_ready(cw_ready),
        .window(win), .level(level),
        .take(fire), .take_len(cw_len)
    );

    dd_lut #(.AW(SM_AW), .DW(INSTR_W)) u_small (
        .clk(clk), .we(sm_we), .waddr(sm_waddr), .wdata(sm_wdata),
        .raddr(sm_raddr), .rdata(sm_rdata)
    );

    dd_lut #(.AW(LG_AW), .DW(INSTR_W)) u_large (
        .clk(clk), .we(lg_we), .waddr(lg_waddr), .wdata(lg_wdata),
        .raddr(lg_raddr), .rdata(lg_rdata)
    );

    dd_decoder #(.SM_AW(SM_AW), .LG_AW(LG_AW), .CNT_W(CNT_W)) u_dec (
        .win(win), .level(level),
        .sm_rdata(sm_rdata), .lg_rdata(lg_rdata),
        .sm_raddr(sm_raddr), .lg_raddr(lg_raddr),
        .tag(tag), .instr(instr), .cw_len(cw_len), .complete(complete)
    );

    dd_out_fifo #(.DEPTH(Q_DEPTH), .W(INSTR_W)) u_q (
        .clk(clk), .rst_n(rst_n),
        .push(fire), .push_data(instr), .full(q_full),
        .rd_valid(ins_valid), .rd_data(ins_data), .rd_ready(ins_ready)
    );

    AST_PATCH_DISTANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && tag == CW_PATCH) |-> $countones(instr ^ lg_rdata) <= 2); // R4
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !ins_valid && cw_ready); // R1
    AST_LARGE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && tag == CW_LARGE) |-> instr == lg_rdata); // R3
endmodule

// File: tb/tb_dd_decomp.sv
module tb_dd_decomp;
    localparam int SM = 3;
    localparam int LG = 5;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          cw_valid = 0;
    logic [31:0]   cw_data = '0;
    logic          cw_ready;
    logic          sm_we = 0;
    logic [SM-1:0] sm_waddr = '0;
    logic [31:0]   sm_wdata = '0;
    logic          lg_we = 0;
    logic [LG-1:0] lg_waddr = '0;
    logic [31:0]   lg_wdata = '0;
    logic          ins_valid;
    logic [31:0]   ins_data;
    logic          ins_ready = 0;

    dd_decomp #(.SM_AW(SM), .LG_AW(LG)) dut (
        .clk(clk), .rst_n(rst_n),
        .cw_valid(cw_valid), .cw_data(cw_data), .cw_ready(cw_ready),
        .sm_we(sm_we), .sm_waddr(sm_waddr), .sm_wdata(sm_wdata),
        .lg_we(lg_we), .lg_waddr(lg_waddr), .lg_wdata(lg_wdata),
        .ins_valid(ins_valid), .ins_data(ins_data), .ins_ready(ins_ready)
    );

    always #10 clk = ~clk;

    int tests = 0, fails = 0, cyc = 0;
    bit done = 0;
    logic [31:0] sm_ref [1 << SM];
    logic [31:0] lg_ref [1 << LG];
    bit          bs [$];
    logic [31:0] words [$];
    logic [31:0] exp_q [$];
    string       exp_r [$];

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++; tests++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic put(input logic [33:0] v, input int n);
        for (int b = 0; b < n; b++) bs.push_back(v[b]);
    endtask

    task automatic enc_small(input int i);
        put({29'(i), 2'b00}, 2 + SM);
        exp_q.push_back(sm_ref[i]); exp_r.push_back("R2");
    endtask
    task automatic enc_large(input int i);
        put({29'(i), 2'b01}, 2 + LG);
        exp_q.push_back(lg_ref[i]); exp_r.push_back("R3");
    endtask
    task automatic enc_patch(input int i, input int p, input int q);
        put({21'(i), 2'(q), 4'(p), 2'b10}, 8 + LG);
        exp_q.push_back(lg_ref[i] ^ (32'(q) << (2 * p))); exp_r.push_back("R4");
    endtask
    task automatic enc_raw(input logic [31:0] v);
        put({v, 2'b11}, 34);
        exp_q.push_back(v); exp_r.push_back("R5");
    endtask

    // Pad with small codewords to a word boundary and pack into words (R6).
    task automatic pack();
        while (bs.size() % 32 != 0) enc_small(0);
        words.delete();
        for (int k = 0; k < bs.size() / 32; k++) begin
            logic [31:0] w;
            for (int b = 0; b < 32; b++) w[b] = bs[32 * k + b];
            words.push_back(w);
        end
        bs.delete();
    endtask

    task automatic wr_sm(input int i, input logic [31:0] v);
        @(negedge clk); sm_we = 1; sm_waddr = SM'(i); sm_wdata = v; sm_ref[i] = v;
        @(negedge clk); sm_we = 0;
    endtask
    task automatic wr_lg(input int i, input logic [31:0] v);
        @(negedge clk); lg_we = 1; lg_waddr = LG'(i); lg_wdata = v; lg_ref[i] = v;
        @(negedge clk); lg_we = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; cw_valid = 0; ins_ready = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(ins_valid == 0, "R1 ins_valid", 32'(ins_valid), 0);
        chk(cw_ready == 1, "R1 cw_ready", 32'(cw_ready), 1);
    endtask

    // Stream the packed words, compare every output in order (R6, R8).
    task automatic run(input int pct);
        int wi = 0;
        int idle = 0;
        while ((exp_q.size() > 0 || wi < words.size()) && idle < 2000) begin
            @(negedge clk);
            idle++;
            if (wi < words.size()) begin
                cw_valid = 1; cw_data = words[wi];
                if (cw_ready) begin wi++; idle = 0; end
            end else cw_valid = 0;
            ins_ready = (($urandom % 100) < pct);
            if (ins_valid && ins_ready) begin
                idle = 0;
                if (exp_q.size() == 0) chk(0, "R6 extra output", ins_data, 0);
                else begin
                    logic [31:0] e = exp_q.pop_front();
                    string r = exp_r.pop_front();
                    chk(ins_data == e, r, ins_data, e);
                end
            end
        end
        chk(exp_q.size() == 0, "R6 missing outputs", 32'(exp_q.size()), 0);
        cw_valid = 0; ins_ready = 1;
        repeat (20) @(negedge clk);
        chk(ins_valid == 0, "R6 no spurious output", 32'(ins_valid), 0);
        exp_q.delete(); exp_r.delete();
    endtask

    initial begin
        for (int i = 0; i < (1 << SM); i++) wr_sm(i, $urandom);
        for (int i = 0; i < (1 << LG); i++) wr_lg(i, $urandom);
        do_reset();

        // Sweep every table entry, every patch position/value, raws, mix.
        for (int i = 0; i < (1 << SM); i++) enc_small(i);
        for (int i = 0; i < (1 << LG); i++) enc_large(i);
        for (int p = 0; p < 16; p++)
            for (int q = 0; q < 4; q++) enc_patch((p * 4 + q) % (1 << LG), p, q);
        for (int i = 0; i < 20; i++) enc_raw($urandom);
        for (int i = 0; i < 300; i++) begin
            case ($urandom % 4)
                0: enc_small($urandom % (1 << SM));
                1: enc_large($urandom % (1 << LG));
                2: enc_patch($urandom % (1 << LG), $urandom % 16, $urandom % 4);
                default: enc_raw($urandom);
            endcase
        end
        pack();
        run(70);

        // R9: rewritten entries take effect for later codewords.
        wr_sm(1, 32'hA5A5_0001);
        wr_lg(3, 32'h5A5A_0003);
        enc_small(1); exp_r[exp_r.size() - 1] = "R9";
        enc_large(3); exp_r[exp_r.size() - 1] = "R9";
        enc_patch(3, 15, 3); exp_r[exp_r.size() - 1] = "R9";
        pack();
        run(100);

        // R7/R8: output blocked from reset with a raw-only stream.
        do_reset();
        for (int i = 0; i < 10; i++) enc_raw($urandom);
        pack();
        begin
            int acc = 0;
            ins_ready = 0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (acc < words.size()) begin
                    cw_valid = 1; cw_data = words[acc];
                    if (cw_ready) acc++;
                end
            end
            chk(acc == 6, "R7 words accepted", 32'(acc), 6);
            chk(cw_ready == 0, "R7 ready low when full", 32'(cw_ready), 0);
            chk(ins_valid == 1, "R8 queue holds", 32'(ins_valid), 1);
            chk(ins_data == exp_q[0], "R8 head steady", ins_data, exp_q[0]);
            for (int k = 0; k < acc; k++) void'(words.pop_front());
        end
        run(100);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule